// File: doc/BRIEF.md
# Interrupt context save/restore unit

This unit keeps a processor's return context while an exception or interrupt is being handled. It has two save banks. The first holds the return address and status word for software exceptions and maskable interrupts. The second holds them for non-maskable interrupts. When an event is accepted, the unit stores the address of the instruction that follows the interrupted one and the current status word into the bank for that event type. The other bank is left as it was.

A return command reloads the processor's program counter and status word from one bank. A select bit on the command picks the bank. The restored values appear one cycle after the command, together with a one-cycle valid strobe. A handler can save or restore the four registers through a software write port. Each bank has only one slot, so there is no stacking. A handler that allows nesting must copy the registers away first.

Only the low 26 bits of a saved address and the low 8 bits of a saved status word exist. The upper bits always read as zero, whether the value came from an event capture or from a software write.

Top module: `ctx_save_unit`

## Requirements
- R1: When `mi_accept` is 1 and `nmi_accept` is 0, the maskable bank (`mi_pc`, `mi_psw`) holds the masked `next_pc` and `cur_psw` after the next rising clock edge.
- R2: When `nmi_accept` is 1, the NMI bank (`nmi_pc`, `nmi_psw`) captures the masked `next_pc` and `cur_psw`, and the maskable bank does not change.
- R3: When `nmi_accept` and `mi_accept` are both 1 in the same cycle, only the NMI bank captures.
- R4: Bits 31..26 of every saved address and bits 31..8 of every saved status word are always 0, both after a capture and after a software write.
- R5: When `sw_we` is 1, `sw_wdata` is written to one register chosen by `sw_addr`. The encoding is 0 = maskable address, 1 = maskable status, 2 = NMI address, 3 = NMI status. Bit 1 selects the bank and bit 0 selects the field.
- R6: If an event capture and a software write target the same bank in the same cycle, the capture wins. A write to the other bank in that cycle still takes effect.
- R7: When `ret_req` is 1 and `ret_sel_nmi` is 0, `ret_pc` and `ret_psw` present the maskable bank contents as they were before that edge. `ret_valid` is 1 for exactly the following cycle.
- R8: When `ret_req` is 1 and `ret_sel_nmi` is 1, the restore values come from the NMI bank instead.
- R9: While `rst_n` is 0, and after it is released, all four save registers and both restore outputs are zero and `ret_valid` is 0.
- R10: A second maskable event overwrites the first saved context. No earlier value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| next_pc | input | 32 | Address of the instruction after the interrupted one |
| cur_psw | input | 32 | Current program status word |
| mi_accept | input | 1 | Software exception or maskable interrupt accepted |
| nmi_accept | input | 1 | Non-maskable interrupt accepted |
| ret_req | input | 1 | Return-from-interrupt command |
| ret_sel_nmi | input | 1 | Restore source: 1 = NMI bank, 0 = maskable bank |
| sw_we | input | 1 | Software write enable |
| sw_addr | input | 2 | Software register select |
| sw_wdata | input | 32 | Software write data |
| mi_pc | output | 32 | Maskable bank saved address |
| mi_psw | output | 32 | Maskable bank saved status |
| nmi_pc | output | 32 | NMI bank saved address |
| nmi_psw | output | 32 | NMI bank saved status |
| ret_valid | output | 1 | Restore values valid (one cycle) |
| ret_pc | output | 32 | Restored program counter |
| ret_psw | output | 32 | Restored status word |

## Verification
The hardest cases to reach are those where several sources compete for one register in the same cycle. These are an NMI and a maskable event arriving together, a capture colliding with a software write to the same bank, and a return command issued in the cycle that overwrites the bank it reads from. The vector table drives each of these collisions as a single cycle. It then checks the following:
- the losing source left no trace;
- a write aimed at the other bank still landed;
- the restored values are the ones from before the overwrite.

All-ones patterns on the event inputs and the write port expose any reserved bit that is not forced to zero.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

   localparam int unsigned CTX_NUM_BANKS = 2;

   typedef enum logic {
      BANK_MI  = 1'b0,
      BANK_NMI = 1'b1
   } ctx_bank_e;

   typedef enum logic {
      FIELD_PC  = 1'b0,
      FIELD_PSW = 1'b1
   } ctx_field_e;

   function automatic logic [31:0] ctx_low_mask(input int unsigned bits);
      logic [31:0] m;
      for (int i = 0; i < 32; i++) m[i] = (i < bits);
      return m;
   endfunction

endpackage

// File: rtl/ctx_bank.sv
module ctx_bank #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned PC_BITS  = 26,
   parameter int unsigned PSW_BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap,
   input  logic [XLEN-1:0] cap_pc,
   input  logic [XLEN-1:0] cap_psw,
   input  logic            wr_pc,
   input  logic            wr_psw,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] out_pc,
   output logic [XLEN-1:0] out_psw
);

   localparam logic [XLEN-1:0] PC_MASK  = XLEN'(ctx_save_pkg::ctx_low_mask(PC_BITS));
   localparam logic [XLEN-1:0] PSW_MASK = XLEN'(ctx_save_pkg::ctx_low_mask(PSW_BITS));

   generate
      if (PC_BITS == 0 || PC_BITS > XLEN)
         $error("ctx_bank: PC_BITS must lie in 1..XLEN");
      if (PSW_BITS == 0 || PSW_BITS > XLEN)
         $error("ctx_bank: PSW_BITS must lie in 1..XLEN");
   endgenerate

   logic [PC_BITS-1:0]  pc_q;
   logic [PSW_BITS-1:0] psw_q;

   wire unused_hi = ^{cap_pc, cap_psw, wr_data};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= '0;
         psw_q <= '0;
      end else if (cap) begin
         pc_q  <= cap_pc[PC_BITS-1:0];
         psw_q <= cap_psw[PSW_BITS-1:0];
      end else begin
         if (wr_pc)  pc_q  <= wr_data[PC_BITS-1:0];
         if (wr_psw) psw_q <= wr_data[PSW_BITS-1:0];
      end
   end

   generate
      if (PC_BITS < XLEN) begin : g_pc_pad
         assign out_pc = {{(XLEN-PC_BITS){1'b0}}, pc_q};
      end else begin : g_pc_full
         assign out_pc = pc_q;
      end
      if (PSW_BITS < XLEN) begin : g_psw_pad
         assign out_psw = {{(XLEN-PSW_BITS){1'b0}}, psw_q};
      end else begin : g_psw_full
         assign out_psw = psw_q;
      end
   endgenerate

   // R1 / R4: a capture lands masked on the outputs one edge later
   p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (out_pc == ($past(cap_pc) & PC_MASK)) && (out_psw == ($past(cap_psw) & PSW_MASK)));

   // R5 / R4: a software write without a capture lands masked
   p_write_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pc && !cap) |=> out_pc == ($past(wr_data) & PC_MASK));

   p_write_psw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_psw && !cap) |=> out_psw == ($past(wr_data) & PSW_MASK));

   // R6: with no source active the bank holds
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap && !wr_pc && !wr_psw) |=> $stable(out_pc) && $stable(out_psw));

endmodule

// File: rtl/ctx_restore.sv
module ctx_restore #(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ret_req,
   input  logic            ret_sel_nmi,
   input  logic [XLEN-1:0] mi_pc,
   input  logic [XLEN-1:0] mi_psw,
   input  logic [XLEN-1:0] nmi_pc,
   input  logic [XLEN-1:0] nmi_psw,
   output logic            ret_valid,
   output logic [XLEN-1:0] ret_pc,
   output logic [XLEN-1:0] ret_psw
);

   logic [XLEN-1:0] src_pc, src_psw;

   always_comb begin
      src_pc  = ret_sel_nmi ? nmi_pc  : mi_pc;
      src_psw = ret_sel_nmi ? nmi_psw : mi_psw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ret_valid <= 1'b0;
         ret_pc    <= '0;
         ret_psw   <= '0;
      end else begin
         ret_valid <= ret_req;
         if (ret_req) begin
            ret_pc  <= src_pc;
            ret_psw <= src_psw;
         end
      end
   end

   // R7: the strobe follows the command by exactly one cycle
   p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_req |=> ret_valid);

   p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_req |=> !ret_valid);

   p_src_mi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !ret_sel_nmi) |=> (ret_pc == $past(mi_pc)) && (ret_psw == $past(mi_psw)));

   // R8: NMI bank as the source
   p_src_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && ret_sel_nmi) |=> (ret_pc == $past(nmi_pc)) && (ret_psw == $past(nmi_psw)));

endmodule

// File: rtl/ctx_save_unit.sv
module ctx_save_unit #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned PC_BITS  = 26,
   parameter int unsigned PSW_BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] next_pc,
   input  logic [XLEN-1:0] cur_psw,
   input  logic            mi_accept,
   input  logic            nmi_accept,
   input  logic            ret_req,
   input  logic            ret_sel_nmi,
   input  logic            sw_we,
   input  logic [1:0]      sw_addr,
   input  logic [XLEN-1:0] sw_wdata,
   output logic [XLEN-1:0] mi_pc,
   output logic [XLEN-1:0] mi_psw,
   output logic [XLEN-1:0] nmi_pc,
   output logic [XLEN-1:0] nmi_psw,
   output logic            ret_valid,
   output logic [XLEN-1:0] ret_pc,
   output logic [XLEN-1:0] ret_psw
);

   import ctx_save_pkg::*;

   localparam int unsigned NB = CTX_NUM_BANKS;

   logic [NB-1:0]   cap_v, wr_pc_v, wr_psw_v;
   logic [XLEN-1:0] bank_pc  [NB];
   logic [XLEN-1:0] bank_psw [NB];

   // NMI takes precedence: a simultaneous maskable event is not captured
   always_comb begin
      cap_v           = '0;
      cap_v[BANK_NMI] = nmi_accept;
      cap_v[BANK_MI]  = mi_accept & ~nmi_accept;
   end

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         assign wr_pc_v[b]  = sw_we && (sw_addr[1] == b[0]) && (sw_addr[0] == FIELD_PC);
         assign wr_psw_v[b] = sw_we && (sw_addr[1] == b[0]) && (sw_addr[0] == FIELD_PSW);

         ctx_bank #(
            .XLEN    (XLEN),
            .PC_BITS (PC_BITS),
            .PSW_BITS(PSW_BITS)
         ) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap    (cap_v[b]),
            .cap_pc (next_pc),
            .cap_psw(cur_psw),
            .wr_pc  (wr_pc_v[b]),
            .wr_psw (wr_psw_v[b]),
            .wr_data(sw_wdata),
            .out_pc (bank_pc[b]),
            .out_psw(bank_psw[b])
         );
      end
   endgenerate

   assign mi_pc   = bank_pc[BANK_MI];
   assign mi_psw  = bank_psw[BANK_MI];
   assign nmi_pc  = bank_pc[BANK_NMI];
   assign nmi_psw = bank_psw[BANK_NMI];

   ctx_restore #(.XLEN(XLEN)) restore_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ret_req    (ret_req),
      .ret_sel_nmi(ret_sel_nmi),
      .mi_pc      (mi_pc),
      .mi_psw     (mi_psw),
      .nmi_pc     (nmi_pc),
      .nmi_psw    (nmi_psw),
      .ret_valid  (ret_valid),
      .ret_pc     (ret_pc),
      .ret_psw    (ret_psw)
   );

   // R2 / R3: an NMI leaves the maskable bank alone unless software writes it
   p_nmi_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_accept && !(sw_we && !sw_addr[1])) |=> $stable(mi_pc) && $stable(mi_psw));

   // R2: an NMI capture reaches the NMI bank outputs
   p_nmi_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_accept |=> nmi_pc[PC_BITS-1:0] == $past(next_pc[PC_BITS-1:0]));

   // R6: a maskable event beats a software write to the same bank
   p_cap_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mi_accept && !nmi_accept && sw_we && !sw_addr[1]) |=>
         (mi_pc[PC_BITS-1:0] == $past(next_pc[PC_BITS-1:0])) &&
         (mi_psw[PSW_BITS-1:0] == $past(cur_psw[PSW_BITS-1:0])));

endmodule

// File: tb/ctx_save_unit_tb_top.sv
module ctx_save_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] next_pc, cur_psw, sw_wdata;
   logic        mi_accept, nmi_accept, ret_req, ret_sel_nmi, sw_we;
   logic [1:0]  sw_addr;
   logic [31:0] mi_pc, mi_psw, nmi_pc, nmi_psw, ret_pc, ret_psw;
   logic        ret_valid;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ctx_save_unit dut_i (
      .clk(clk), .rst_n(rst_n), .next_pc(next_pc), .cur_psw(cur_psw),
      .mi_accept(mi_accept), .nmi_accept(nmi_accept), .ret_req(ret_req),
      .ret_sel_nmi(ret_sel_nmi), .sw_we(sw_we), .sw_addr(sw_addr),
      .sw_wdata(sw_wdata), .mi_pc(mi_pc), .mi_psw(mi_psw), .nmi_pc(nmi_pc),
      .nmi_psw(nmi_psw), .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_psw(ret_psw)
   );

   typedef struct packed {
      logic        mi, nmi, ret, sel, we;
      logic [1:0]  addr;
      logic [31:0] wdata, npc, psw;
      logic [31:0] e_mpc, e_mpsw, e_npc, e_npsw;
      logic        e_rv;
      logic [31:0] e_rpc, e_rpsw;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      // R1 R4: all-ones capture into maskable bank
      '{1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,32'h0,32'hFFFF_FFFF,32'hFFFF_FFFF,
        32'h03FF_FFFF,32'h0000_00FF,32'h0,32'h0,1'b0,32'h0,32'h0},
      // R10: second maskable event overwrites
      '{1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,32'h0,32'h0000_1234,32'h0000_0021,
        32'h0000_1234,32'h21,32'h0,32'h0,1'b0,32'h0,32'h0},
      // R2 R4: NMI capture, reserved bits dropped
      '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,32'h0,32'h0400_0A00,32'h1234_5680,
        32'h0000_1234,32'h21,32'h0A00,32'h80,1'b0,32'h0,32'h0},
      // R3: both events together, only NMI bank moves
      '{1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,32'h0,32'h0000_0B00,32'h0000_0007,
        32'h0000_1234,32'h21,32'h0B00,32'h07,1'b0,32'h0,32'h0},
      // R7: return from maskable bank
      '{1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,32'h0,32'h0,32'h0,
        32'h0000_1234,32'h21,32'h0B00,32'h07,1'b1,32'h1234,32'h21},
      // R8: return from NMI bank
      '{1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,32'h0,32'h0,32'h0,
        32'h0000_1234,32'h21,32'h0B00,32'h07,1'b1,32'h0B00,32'h07},
      // R7: strobe lasts one cycle
      '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,32'h0,32'h0,32'h0,
        32'h0000_1234,32'h21,32'h0B00,32'h07,1'b0,32'h0,32'h0},
      // R5 R4: software writes to all four addresses
      '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,32'hFFFF_0010,32'h0,32'h0,
        32'h03FF_0010,32'h21,32'h0B00,32'h07,1'b0,32'h0,32'h0},
      '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,32'hAAAA_AA55,32'h0,32'h0,
        32'h03FF_0010,32'h55,32'h0B00,32'h07,1'b0,32'h0,32'h0},
      '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,32'h0000_0100,32'h0,32'h0,
        32'h03FF_0010,32'h55,32'h0100,32'h07,1'b0,32'h0,32'h0},
      '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,32'h0000_01FE,32'h0,32'h0,
        32'h03FF_0010,32'h55,32'h0100,32'hFE,1'b0,32'h0,32'h0},
      // R6: capture beats write to same bank
      '{1'b1,1'b0,1'b0,1'b0,1'b1,2'd0,32'h0000_0FFF,32'h0000_2000,32'h0000_0003,
        32'h0000_2000,32'h03,32'h0100,32'hFE,1'b0,32'h0,32'h0},
      // R6: write to the other bank still lands
      '{1'b1,1'b0,1'b0,1'b0,1'b1,2'd2,32'h0000_0555,32'h0000_3000,32'h0000_0004,
        32'h0000_3000,32'h04,32'h0555,32'hFE,1'b0,32'h0,32'h0},
      // R7: return reads pre-edge value while bank is overwritten
      '{1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,32'h0,32'h0000_4000,32'h0000_0005,
        32'h0000_4000,32'h05,32'h0555,32'hFE,1'b1,32'h3000,32'h04}
   };

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      mi_accept = 0; nmi_accept = 0; ret_req = 0; ret_sel_nmi = 0; sw_we = 0;
      sw_addr = 0; sw_wdata = 0; next_pc = 0; cur_psw = 0;
   endtask

   task automatic chk_zero(input string tag);
      chk(tag, "mi_pc", mi_pc, 0);
      chk(tag, "mi_psw", mi_psw, 0);
      chk(tag, "nmi_pc", nmi_pc, 0);
      chk(tag, "nmi_psw", nmi_psw, 0);
      chk(tag, "ret_valid", {31'b0, ret_valid}, 0);
      chk(tag, "ret_pc", ret_pc, 0);
      chk(tag, "ret_psw", ret_psw, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk_zero("R9");
      rst_n = 1;
      @(negedge clk);
      chk_zero("R9");

      for (int i = 0; i < NV; i++) begin
         mi_accept = VEC[i].mi;  nmi_accept = VEC[i].nmi;
         ret_req = VEC[i].ret;   ret_sel_nmi = VEC[i].sel;
         sw_we = VEC[i].we;      sw_addr = VEC[i].addr;
         sw_wdata = VEC[i].wdata; next_pc = VEC[i].npc; cur_psw = VEC[i].psw;
         @(negedge clk);
         chk($sformatf("vec%0d", i), "mi_pc", mi_pc, VEC[i].e_mpc);
         chk($sformatf("vec%0d", i), "mi_psw", mi_psw, VEC[i].e_mpsw);
         chk($sformatf("vec%0d", i), "nmi_pc", nmi_pc, VEC[i].e_npc);
         chk($sformatf("vec%0d", i), "nmi_psw", nmi_psw, VEC[i].e_npsw);
         chk($sformatf("vec%0d", i), "ret_valid", {31'b0, ret_valid}, {31'b0, VEC[i].e_rv});
         if (VEC[i].e_rv) begin
            chk($sformatf("vec%0d", i), "ret_pc", ret_pc, VEC[i].e_rpc);
            chk($sformatf("vec%0d", i), "ret_psw", ret_psw, VEC[i].e_rpsw);
         end
      end

      // R7: strobe drops after the last return
      idle();
      @(negedge clk);
      chk("R7", "ret_valid drop", {31'b0, ret_valid}, 0);

      // R9: reset in mid-run clears everything
      rst_n = 0;
      @(negedge clk);
      chk_zero("R9");
      rst_n = 1;

      // R8: return right after reset gives zeros with a strobe
      ret_req = 1; ret_sel_nmi = 1;
      @(negedge clk);
      idle();
      chk("R8", "ret_valid", {31'b0, ret_valid}, 1);
      chk("R8", "ret_pc", ret_pc, 0);
      chk("R8", "ret_psw", ret_psw, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule